// File: doc/BRIEF.md
# Maintenance Control and Watchdog Unit

This block holds a 32-bit maintenance control word for a processor, together with the logic it drives. Single bits of the word block automatic instruction retry, turn off parity checking of register transactions, stop the program counter from advancing (so one instruction repeats), and force the processor to halt. The upper half carries a load device address that is presented as an output field. Reserved bits cannot be written and always read back as zero.

A down-counting watchdog belongs to the same block. It reloads on a restart pulse and on any reset. When it runs out it raises a one-cycle request. In the normal mode that request is a trap. In the alarm mode it is a system-reset request instead, and the counter starts over so that the machine keeps cycling through the same reset for fault isolation. Another control bit freezes the counter completely.

The control word has a reset immunity that sets it apart: processor and system resets, including the one the watchdog itself requests, leave it untouched. Only power-on and the super-reset command clear it.

Top module: `maint_ctl_unit`

## Requirements
- R1: When `por_i` or `super_rst_i` is high at a clock edge, the control word becomes zero from that edge on: readback 0, `retry_en_o`=1, `parity_chk_en_o`=1, `pc_inc_inhibit_o`=0, `halt_o`=0, `load_dev_addr_o`=0. This takes priority over a write in the same cycle.
- R2: A high `proc_rst_i` or `sys_rst_i` leaves the control word unchanged.
- R3: A high `wr_en_i` at an edge loads `wr_data_i` into the word, and `ctl_word_o` shows it after that edge. Bits 4, 5 and 8 to 15 are ignored on write and always read as zero, which gives a keep mask of 0xFFFF00CF.
- R4: `retry_en_o` is the inverse of bit 0. `parity_chk_en_o` is the inverse of bit 1.
- R5: `pc_inc_inhibit_o` follows bit 6. `halt_o` follows bit 7.
- R6: `load_dev_addr_o` equals bits 31 to 16 of the word.
- R7: The watchdog counter reloads to `WDT_LOAD` on any of these at an edge: `por_i`, `super_rst_i`, `proc_rst_i`, `sys_rst_i`, or `wdt_restart_i`. It then decrements once per clock edge. At the first edge where it is already zero, it raises a request that lasts exactly one cycle and reloads. The request therefore appears after the (`WDT_LOAD`+1)-th edge following the reloading edge.
- R8: While bit 2 of the word (override) is 1, the counter holds its value and neither request is raised.
- R9: While bit 3 (alarm mode) is 0, an expiry pulses `wdt_trap_o`. While it is 1, an expiry pulses `sys_rst_req_o` instead, and the watchdog continues counting to the next expiry. The two requests are never high together.
- R10: A system reset that results from the watchdog's own request reloads the counter, so the period becomes `WDT_LOAD`+2 cycles when the request is fed back one cycle later. It does not alter the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| super_rst_i | input | 1 | Super-reset command, clears the word |
| proc_rst_i | input | 1 | Processor reset, reloads watchdog only |
| sys_rst_i | input | 1 | System reset, reloads watchdog only |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| wdt_restart_i | input | 1 | Watchdog restart pulse |
| ctl_word_o | output | 32 | Control word readback |
| retry_en_o | output | 1 | Automatic instruction retry allowed |
| parity_chk_en_o | output | 1 | Register parity checking enabled |
| pc_inc_inhibit_o | output | 1 | Program counter increment blocked |
| halt_o | output | 1 | Processor forced to halt |
| load_dev_addr_o | output | 16 | Load device address field |
| wdt_trap_o | output | 1 | Watchdog trap request, one-cycle pulse |
| sys_rst_req_o | output | 1 | Watchdog system-reset request, one-cycle pulse |

## Verification
Register writes and clears show at every decoded output one edge after the strobe, because the decode is combinational from the stored word. A watchdog request shows exactly `WDT_LOAD`+1 edges after the reloading edge. Mode and override bits take effect from the edge after they are written, since the counter sees the word as it was stored before that edge. The bench drives inputs and samples outputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, so both sides are compared after an identical number of edges. Directed checks count falling edges from a restart to confirm the exact cycle of a pulse and the number of pulses in a window.

// File: rtl/maint_ctl_pkg.sv
package maint_ctl_pkg;
    localparam int WORD_W    = 32;
    localparam int DEV_W     = 16;
    localparam int DEV_LSB   = 16;
    localparam int B_RETRY   = 0;
    localparam int B_PARITY  = 1;
    localparam int B_WDT_OVR = 2;
    localparam int B_ALARM   = 3;
    localparam int B_HOLD    = 6;
    localparam int B_HALT    = 7;
    // bits kept on write; reserved bits 4,5 and 8..15 are dropped
    localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFFFF_00CF;

    typedef struct packed {
        logic [DEV_W-1:0] dev_addr;
        logic             halt;
        logic             addr_hold;
        logic             wdt_alarm;
        logic             wdt_ovr;
        logic             parity_inh;
        logic             retry_inh;
    } ctl_fields_t;
endpackage

// File: rtl/mcu_ctl_reg.sv
module mcu_ctl_reg
    import maint_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              super_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] word_o,
    output ctl_fields_t       fields_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i || super_i) begin
            st_d.word = '0;
        end else if (wr_en_i) begin
            st_d.word = wr_data_i & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        fields_o.retry_inh  = st_q.word[B_RETRY];
        fields_o.parity_inh = st_q.word[B_PARITY];
        fields_o.wdt_ovr    = st_q.word[B_WDT_OVR];
        fields_o.wdt_alarm  = st_q.word[B_ALARM];
        fields_o.addr_hold  = st_q.word[B_HOLD];
        fields_o.halt       = st_q.word[B_HALT];
        fields_o.dev_addr   = st_q.word[DEV_LSB +: DEV_W];
    end

    assign word_o = st_q.word;

    // R1: super reset clears the word on the next edge
    assert_super_clear_R1: assert property (@(posedge clk) disable iff (por_i)
        super_i |=> (word_o == '0));

    // R3: a write without clear shows the masked data afterwards
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (por_i)
        (wr_en_i && !super_i) |=> (word_o == ($past(wr_data_i) & KEEP_MASK)));
endmodule

// File: rtl/mcu_wdt.sv
module mcu_wdt #(
    parameter int WDT_LOAD = 1024
) (
    input  logic clk,
    input  logic por_i,
    input  logic reload_i,
    input  logic ovr_i,
    input  logic alarm_i,
    output logic trap_o,
    output logic rst_req_o
);
    localparam int CNT_W = $clog2(WDT_LOAD + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WDT_LOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trap;
        logic             rst_req;
    } wdt_state_t;

    wdt_state_t st_d, st_q;
    logic       reload;
    logic       expire;

    assign reload = por_i || reload_i;
    assign expire = !reload && !ovr_i && (st_q.cnt == '0);

    always_comb begin
        st_d         = st_q;
        st_d.trap    = 1'b0;
        st_d.rst_req = 1'b0;
        if (reload) begin
            st_d.cnt = LOAD_V;
        end else if (ovr_i) begin
            st_d.cnt = st_q.cnt;
        end else if (expire) begin
            st_d.cnt = LOAD_V;
            if (alarm_i) begin
                st_d.rst_req = 1'b1;
            end else begin
                st_d.trap = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign trap_o    = st_q.trap;
    assign rst_req_o = st_q.rst_req;

    // R7: any reload source returns the counter to the load value
    assert_reload_value_R7: assert property (@(posedge clk) disable iff (por_i)
        reload_i |=> (st_q.cnt == LOAD_V));

    // R7: a request lasts a single cycle
    assert_trap_single_R7: assert property (@(posedge clk) disable iff (por_i)
        trap_o |=> !trap_o);

    // R8: override suppresses both requests and freezes the count
    assert_override_quiet_R8: assert property (@(posedge clk) disable iff (por_i)
        (ovr_i && !reload_i) |=> (!trap_o && !rst_req_o && $stable(st_q.cnt)));

    // R9: the two requests are exclusive
    assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (por_i)
        $onehot0({trap_o, rst_req_o}));
endmodule

// File: rtl/maint_ctl_unit.sv
module maint_ctl_unit
    import maint_ctl_pkg::*;
#(
    parameter int WDT_LOAD = 1024
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              super_rst_i,
    input  logic              proc_rst_i,
    input  logic              sys_rst_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              wdt_restart_i,
    output logic [WORD_W-1:0] ctl_word_o,
    output logic              retry_en_o,
    output logic              parity_chk_en_o,
    output logic              pc_inc_inhibit_o,
    output logic              halt_o,
    output logic [DEV_W-1:0]  load_dev_addr_o,
    output logic              wdt_trap_o,
    output logic              sys_rst_req_o
);
    ctl_fields_t fields;
    logic        wdt_reload;

    mcu_ctl_reg u_reg (
        .clk       (clk),
        .por_i     (por_i),
        .super_i   (super_rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .word_o    (ctl_word_o),
        .fields_o  (fields)
    );

    // processor and system resets only reach the watchdog
    assign wdt_reload = super_rst_i || proc_rst_i || sys_rst_i || wdt_restart_i;

    mcu_wdt #(.WDT_LOAD(WDT_LOAD)) u_wdt (
        .clk       (clk),
        .por_i     (por_i),
        .reload_i  (wdt_reload),
        .ovr_i     (fields.wdt_ovr),
        .alarm_i   (fields.wdt_alarm),
        .trap_o    (wdt_trap_o),
        .rst_req_o (sys_rst_req_o)
    );

    assign retry_en_o       = !fields.retry_inh;
    assign parity_chk_en_o  = !fields.parity_inh;
    assign pc_inc_inhibit_o = fields.addr_hold;
    assign halt_o           = fields.halt;
    assign load_dev_addr_o  = fields.dev_addr;

    // R2: processor or system reset keeps the word
    assert_reset_keeps_R2: assert property (@(posedge clk) disable iff (por_i)
        ((proc_rst_i || sys_rst_i) && !wr_en_i && !super_rst_i) |=> $stable(ctl_word_o));

    // R10: the watchdog's own reset request never changes the word
    assert_selfreset_keeps_R10: assert property (@(posedge clk) disable iff (por_i)
        (sys_rst_req_o && !wr_en_i && !super_rst_i) |=> $stable(ctl_word_o));
endmodule

// File: tb/maint_ctl_unit_tb_top.sv
module maint_ctl_unit_tb_top;
    localparam int LOAD = 12;
    localparam logic [31:0] MASK = 32'hFFFF_00CF;

    logic        clk = 1'b0;
    logic        por = 1'b1, super_rst = 1'b0, proc_rst = 1'b0, sys_drv = 1'b0;
    logic        sys_loop = 1'b0, loop_en = 1'b0;
    logic        wr_en = 1'b0, restart = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sys_rst;
    logic [31:0] word;
    logic        retry_en, par_en, pc_inh, halt, trap, rst_req;
    logic [15:0] dev;

    int n_cmp = 0, n_bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sys_rst = sys_drv | sys_loop;

    maint_ctl_unit #(.WDT_LOAD(LOAD)) dut_i (
        .clk(clk), .por_i(por), .super_rst_i(super_rst), .proc_rst_i(proc_rst),
        .sys_rst_i(sys_rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .wdt_restart_i(restart), .ctl_word_o(word), .retry_en_o(retry_en),
        .parity_chk_en_o(par_en), .pc_inc_inhibit_o(pc_inh), .halt_o(halt),
        .load_dev_addr_o(dev), .wdt_trap_o(trap), .sys_rst_req_o(rst_req)
    );

    // behavioural reference model
    logic [31:0] m_word = '0;
    int          m_cnt  = 0;
    bit          m_trap = 0, m_rreq = 0;

    always @(posedge clk) begin
        bit reload;
        reload = por | super_rst | proc_rst | sys_rst | restart;
        m_trap = 0;
        m_rreq = 0;
        if (reload) m_cnt = LOAD;
        else if (m_word[2]) m_cnt = m_cnt;
        else if (m_cnt == 0) begin
            if (m_word[3]) m_rreq = 1; else m_trap = 1;
            m_cnt = LOAD;
        end else m_cnt = m_cnt - 1;
        if (por | super_rst) m_word = '0;
        else if (wr_en) m_word = wr_data & MASK;
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        sys_loop <= loop_en & rst_req;
        if (chk_on) begin
            cmp("R3 readback", word, m_word);
            cmp("R4 retry_en", {31'd0, retry_en}, {31'd0, ~m_word[0]});
            cmp("R4 parity_en", {31'd0, par_en}, {31'd0, ~m_word[1]});
            cmp("R5 pc_inhibit", {31'd0, pc_inh}, {31'd0, m_word[6]});
            cmp("R5 halt", {31'd0, halt}, {31'd0, m_word[7]});
            cmp("R6 dev_addr", {16'd0, dev}, {16'd0, m_word[31:16]});
            cmp("R7 R9 trap", {31'd0, trap}, {31'd0, m_trap});
            cmp("R9 R10 rst_req", {31'd0, rst_req}, {31'd0, m_rreq});
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int pulses, traps;
        tick(3);
        por = 1'b0;
        chk_on = 1'b1;
        // R1 reset state
        cmp("R1 por word", word, 32'h0);
        cmp("R1 por outputs", {retry_en, par_en, pc_inh, halt}, 4'b1100);
        // R3 reserved bits dropped; override set -> R8 frozen
        wr(32'hFFFF_FFFF);
        cmp("R3 mask", word, 32'hFFFF_00CF);
        tick(3 * LOAD);
        cmp("R8 no trap while overridden", {31'd0, trap | rst_req}, 32'd0);
        // R2 processor/system reset keep the word
        proc_rst = 1'b1; tick(); proc_rst = 1'b0;
        sys_drv = 1'b1; tick(2); sys_drv = 1'b0;
        cmp("R2 word kept", word, 32'hFFFF_00CF);
        // R1 super reset
        super_rst = 1'b1; tick(); super_rst = 1'b0;
        cmp("R1 super clear", word, 32'h0);
        // R4 R5 R6 patterns (keep override set)
        wr(32'h1234_0005); cmp("R4 retry inhibit", {31'd0, retry_en}, 32'd0);
        wr(32'hABCD_0006); cmp("R4 parity inhibit", {31'd0, par_en}, 32'd0);
        wr(32'h0000_0044); cmp("R5 hold", {31'd0, pc_inh}, 32'd1);
        wr(32'h8001_0084); cmp("R5 halt", {31'd0, halt}, 32'd1);
        cmp("R6 dev", {16'd0, dev}, 32'h0000_8001);
        // R1 por beats a write
        wr_en = 1'b1; wr_data = 32'h5555_00C4; por = 1'b1; tick();
        wr_en = 1'b0; por = 1'b0;
        cmp("R1 por over write", word, 32'h0);
        // R7 exact timing, trap mode
        restart = 1'b1; tick(); restart = 1'b0;
        tick(LOAD);
        cmp("R7 not yet", {31'd0, trap}, 32'd0);
        tick();
        cmp("R7 trap due", {31'd0, trap}, 32'd1);
        tick();
        cmp("R7 one cycle", {31'd0, trap}, 32'd0);
        // R7 periodic restart keeps it quiet
        traps = 0;
        for (int i = 0; i < 6; i++) begin
            restart = 1'b1; tick(); restart = 1'b0;
            for (int k = 0; k < LOAD - 2; k++) begin tick(); traps += trap; end
        end
        cmp("R7 restarted no trap", traps, 0);
        // R8 override mid-count then release
        restart = 1'b1; tick(); restart = 1'b0; tick(4);
        wr(32'h0000_0004); tick(2 * LOAD);
        wr(32'h0000_0000); tick(2 * LOAD);
        // R9 R10 alarm mode with feedback loop
        wr(32'h0000_0008);
        loop_en = 1'b1;
        restart = 1'b1; tick(); restart = 1'b0;
        pulses = 0; traps = 0;
        for (int k = 0; k < 2 * LOAD + 3; k++) begin
            tick(); pulses += rst_req; traps += trap;
        end
        cmp("R9 R10 reset pulses", pulses, 2);
        cmp("R9 no trap in alarm mode", traps, 0);
        tick(3 * LOAD);
        cmp("R10 word kept", word, 32'h0000_0008);
        loop_en = 1'b0;
        tick(2);
        summary();
    end
endmodule